// File: doc/BRIEF.md
# MFM Write Encoder with Write Precompensation

This block turns a stream of bytes into the serial write-pulse train that a double-density flexible-disk drive expects. Each byte is split into eight 2 µs bit cells, most significant bit first. A data 1 gives a flux transition half a cell after the cell's leading edge. A transition at the leading edge itself (the clock) is placed only when the data bit before and the current data bit are both 0. For marker bytes, one of these clocks is dropped on purpose, which makes a pattern that ordinary data cannot produce.

On inner tracks, adjacent transitions push each other's read-back peaks apart. The encoder looks one bit cell back and one bit cell ahead of every transition. It writes the transition a little early or a little late so that the peak reads back near its nominal place. Every transition, shifted or not, leaves the block as one write pulse of fixed width. The block runs on a tick clock of 25 ns: a cell is 80 ticks, the nominal transition delay is 12 ticks, an early transition is at 5 ticks, a late one at 19 ticks, and a pulse is 10 ticks wide.

The host offers bytes through a valid/ready handshake, one byte held in reserve. It raises the marker strobe together with a marker byte. It supplies the current track number and holds the write gate high for as long as writing should go on.

Top module: `mfm_write_enc`

## Requirements
- R1: A clock transition is written at the start of cell i only when data bit i-1 and data bit i are both 0. The data bit before the first cell of a write burst counts as 0.
- R2: A data bit of 1 gives one transition 40 ticks after that cell's clock slot. A data bit of 0 gives none in the data slot.
- R3: When precompensation is off, every transition appears 12 ticks after its slot start.
- R4: Precompensation is on only when the track input is 43 or more. On track 42 and below, no transition is moved.
- R5: With precompensation on, each transition is compared with the same slot one cell earlier (prev) and one cell later (next). If prev holds a transition and next does not, the transition is written at 5 ticks (early). In the reverse case it is written at 19 ticks (late). Otherwise it stays at 12. For a clock, prev is the clock actually written and next is the clock that the rule of R1 gives for the next cell. Data 0110 therefore writes its third bit 7 ticks early and its second bit 7 ticks late.
- R6: Every transition drives wr_pulse high for exactly 10 ticks.
- R7: When a byte is accepted with mark_in high, the second clock that R1 would give inside that byte is not written. Byte A1h loses the clock of its sixth cell (counted from the MSB), and byte C2h loses the clock of its fifth cell. Each therefore gives 5 pulses instead of 6.
- R8: Bits are sent MSB first. A byte accepted before the last cell of the current byte starts follows it with no gap, so the cell pitch stays 80 ticks across the byte boundary.
- R9: byte_ready is high only when the holding register is empty and the encoder is idle or in the last two cells of its byte. An accepted byte drops byte_ready on the next cycle.
- R10: When wr_en falls, the cell in progress completes and no further transitions follow. Writing also stops after a byte's last cell if no byte is waiting.
- R11: After reset, wr_pulse is low and byte_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write gate; encoding runs while high |
| byte_in | input | 8 | Byte to be written, MSB sent first |
| byte_valid | input | 1 | byte_in and mark_in are offered |
| byte_ready | output | 1 | Holding register can take a byte |
| mark_in | input | 1 | Offered byte is a marker byte (drop one clock) |
| track | input | 7 | Current track number |
| wr_pulse | output | 1 | Fixed-width write pulse per transition |

## Verification
The assertions assume that wr_en and byte_valid change only between clock edges. They also assume that bytes only arrive through the handshake, so a held byte_valid with byte_ready low has no effect. They take the track number to be steady during a byte, because the decision is made once per cell. The stimulus drives every input on the falling edge, changes the track only while the encoder is idle, and offers each byte by waiting for byte_ready. This keeps the pulse-width, spacing and stop-window properties inside the conditions they rely on.

// File: rtl/mfm_enc_pkg.sv
// Shared types for the MFM write encoder.
// Assumes: a transition is shifted at most one step either way.
package mfm_enc_pkg;

    typedef enum logic [1:0] {
        SHIFT_NONE  = 2'd0,
        SHIFT_EARLY = 2'd1,
        SHIFT_LATE  = 2'd2
    } shift_e;

    // Chooses the write shift from the neighbours one cell away.
    function automatic shift_e pick_shift(input logic prev_t, input logic next_t,
                                          input logic enable);
        shift_e s;
        s = SHIFT_NONE;
        if (enable && prev_t && !next_t)
            s = SHIFT_EARLY;
        else if (enable && !prev_t && next_t)
            s = SHIFT_LATE;
        return s;
    endfunction

endpackage

// File: rtl/mfm_byte_feed.sv
// Byte feed: one holding register behind a shifting byte register.
// Serves the current bit, the bit one cell ahead (taken from the held
// byte at a boundary) and the marker flag of the byte being written.
// Assumes load and advance are never high in the same cycle.
module mfm_byte_feed #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_valid,
    input  logic              mark_in,
    output logic              byte_ready,
    input  logic              busy,
    input  logic              load,
    input  logic              advance,
    output logic              cur_bit,
    output logic              next_bit,
    output logic              last_bit,
    output logic              cur_mark,
    output logic              have_next
);
    localparam int IDX_W = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    logic [BYTE_W-1:0] hold_q;
    logic              hold_mark_q;
    logic              hold_full_q;
    logic [BYTE_W-1:0] shift_q;
    logic [IDX_W-1:0]  idx_q;
    logic              mark_q;
    logic              accept;

    assign accept = byte_valid && byte_ready;

    // Holding register: filled by the handshake, emptied by a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_mark_q <= 1'b0;
            hold_full_q <= 1'b0;
        end else if (load) begin
            hold_full_q <= 1'b0;
        end else if (accept) begin
            hold_q      <= byte_in;
            hold_mark_q <= mark_in;
            hold_full_q <= 1'b1;
        end
    end

    // Shift register: takes the held byte, then moves one bit per cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            idx_q   <= '0;
            mark_q  <= 1'b0;
        end else if (load) begin
            shift_q <= hold_q;
            idx_q   <= IDX_TOP;
            mark_q  <= hold_mark_q;
        end else if (advance) begin
            shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
            idx_q   <= idx_q - IDX_ONE;
        end
    end

    // Bit views and the request window for the next byte.
    always_comb begin
        cur_bit    = shift_q[BYTE_W-1];
        last_bit   = (idx_q == '0);
        next_bit   = last_bit ? (hold_full_q & hold_q[BYTE_W-1]) : shift_q[BYTE_W-2];
        cur_mark   = mark_q;
        have_next  = hold_full_q;
        byte_ready = !hold_full_q && (!busy || idx_q <= IDX_ONE);
    end

endmodule

// File: rtl/mfm_cell_rule.sv
// Cell rule: decides, for one bit cell, whether the clock and data slots
// carry a transition and how each one is shifted.
// Assumes the neighbour inputs are the slots one cell away.
module mfm_cell_rule
    import mfm_enc_pkg::*;
(
    input  logic   d_prev,
    input  logic   d_cur,
    input  logic   d_next,
    input  logic   ck_prev,
    input  logic   mark,
    input  logic   ck_seen_one,
    input  logic   pc_en,
    output logic   ck_rule,
    output logic   ck_fire,
    output shift_e ck_shift,
    output logic   d_fire,
    output shift_e d_shift
);
    logic ck_next;

    // Clock insertion, marker drop and neighbour-based shifts.
    always_comb begin
        ck_rule  = !d_prev && !d_cur;
        ck_fire  = ck_rule && !(mark && ck_seen_one);
        ck_next  = !d_cur && !d_next;
        ck_shift = pick_shift(ck_prev, ck_next, pc_en);
        d_fire   = d_cur;
        d_shift  = pick_shift(d_prev, d_next, pc_en);
    end

endmodule

// File: rtl/mfm_pulse_gen.sv
// Pulse stretcher: turns a one-tick fire strobe into a pulse of fixed width.
// Assumes strobes are further apart than the pulse width.
module mfm_pulse_gen #(
    parameter int PULSE_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    localparam int PW = $clog2(PULSE_TICKS + 1);
    localparam logic [PW-1:0] P_LOAD = PW'(PULSE_TICKS);
    localparam logic [PW-1:0] P_ONE  = PW'(1);

    logic [PW-1:0] left_q;

    // Width counter: loads on a strobe, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (fire)
            left_q <= P_LOAD;
        else if (left_q != '0)
            left_q <= left_q - P_ONE;
    end

    assign pulse = (left_q != '0);

endmodule

// File: rtl/mfm_write_enc.sv
// MFM write encoder, top level. Runs a cell timer, makes the clock/data
// decision once at the start of every cell and fires each transition at its
// nominal, early or late tick. Assumes one tick per clk cycle and a track
// number that is steady while a byte is written.
module mfm_write_enc
    import mfm_enc_pkg::*;
#(
    parameter int BYTE_W        = 8,
    parameter int TRACK_W       = 7,
    parameter int CELL_TICKS    = 80,
    parameter int NOM_DLY       = 12,
    parameter int EARLY_DLY     = 5,
    parameter int LATE_DLY      = 19,
    parameter int PULSE_TICKS   = 10,
    parameter int PRECOMP_TRACK = 43
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BYTE_W-1:0]  byte_in,
    input  logic               byte_valid,
    output logic               byte_ready,
    input  logic               mark_in,
    input  logic [TRACK_W-1:0] track,
    output logic               wr_pulse
);
    localparam int TICK_W = $clog2(CELL_TICKS);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CELL_TICKS - 1);
    localparam logic [TICK_W-1:0] TICK_HALF = TICK_W'(CELL_TICKS / 2);
    localparam logic [TICK_W-1:0] TICK_ONE  = TICK_W'(1);
    localparam logic [TRACK_W-1:0] PC_THR   = TRACK_W'(PRECOMP_TRACK);

    // Maps a shift choice to its delay inside a half cell.
    function automatic logic [TICK_W-1:0] dly_of(input shift_e s);
        logic [TICK_W-1:0] d;
        case (s)
            SHIFT_EARLY: d = TICK_W'(EARLY_DLY);
            SHIFT_LATE:  d = TICK_W'(LATE_DLY);
            default:     d = TICK_W'(NOM_DLY);
        endcase
        return d;
    endfunction

    logic              active_q;
    logic [TICK_W-1:0] tick_q;
    logic              dprev_q;
    logic              ckprev_q;
    logic [1:0]        ckcnt_q;
    logic              ck_fire_q;
    logic [TICK_W-1:0] ck_at_q;
    logic              d_fire_q;
    logic [TICK_W-1:0] d_at_q;

    logic   cur_bit, next_bit, last_bit, cur_mark, have_next;
    logic   start, cell_end, go_on, load, advance, decide, pc_en, fire;
    logic   ck_rule, ck_fire, d_fire;
    shift_e ck_shift, d_shift;

    mfm_byte_feed #(.BYTE_W(BYTE_W)) u_feed (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_in    (byte_in),
        .byte_valid (byte_valid),
        .mark_in    (mark_in),
        .byte_ready (byte_ready),
        .busy       (active_q),
        .load       (load),
        .advance    (advance),
        .cur_bit    (cur_bit),
        .next_bit   (next_bit),
        .last_bit   (last_bit),
        .cur_mark   (cur_mark),
        .have_next  (have_next)
    );

    mfm_cell_rule u_rule (
        .d_prev      (dprev_q),
        .d_cur       (cur_bit),
        .d_next      (next_bit),
        .ck_prev     (ckprev_q),
        .mark        (cur_mark),
        .ck_seen_one (ckcnt_q == 2'd1),
        .pc_en       (pc_en),
        .ck_rule     (ck_rule),
        .ck_fire     (ck_fire),
        .ck_shift    (ck_shift),
        .d_fire      (d_fire),
        .d_shift     (d_shift)
    );

    mfm_pulse_gen #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .pulse (wr_pulse)
    );

    // Sequencing strobes derived from the timer and the feed.
    always_comb begin
        pc_en    = (track >= PC_THR);
        start    = !active_q && wr_en && have_next;
        cell_end = active_q && (tick_q == TICK_LAST);
        go_on    = wr_en && (!last_bit || have_next);
        load     = start || (cell_end && go_on && last_bit);
        advance  = cell_end && go_on && !last_bit;
        decide   = active_q && (tick_q == '0);
        fire     = active_q && ((ck_fire_q && tick_q == ck_at_q) ||
                                (d_fire_q && tick_q == d_at_q));
    end

    // Cell timer and run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            tick_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            tick_q   <= '0;
        end else if (cell_end) begin
            active_q <= go_on;
            tick_q   <= '0;
        end else if (active_q) begin
            tick_q   <= tick_q + TICK_ONE;
        end
    end

    // History of the previous cell: data bit and clock actually written.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            dprev_q  <= 1'b0;
            ckprev_q <= 1'b0;
        end else if (cell_end) begin
            dprev_q  <= cur_bit;
            ckprev_q <= ck_fire_q;
        end
    end

    // Count of rule clocks inside the current byte, for the marker drop.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            ckcnt_q <= 2'd0;
        else if (decide && ck_rule && ckcnt_q != 2'd2)
            ckcnt_q <= ckcnt_q + 2'd1;
    end

    // Per-cell schedule latched at the cell's first tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_fire_q <= 1'b0;
            ck_at_q   <= '0;
            d_fire_q  <= 1'b0;
            d_at_q    <= '0;
        end else if (decide) begin
            ck_fire_q <= ck_fire;
            ck_at_q   <= dly_of(ck_shift);
            d_fire_q  <= d_fire;
            d_at_q    <= TICK_HALF + dly_of(d_shift);
        end
    end

endmodule

// File: rtl/mfm_write_enc_chk.sv
// Property checker for the MFM write encoder, attached by bind.
// Assumes inputs change only between clock edges.
module mfm_write_enc_chk #(
    parameter int CELL_TICKS  = 80,
    parameter int PULSE_TICKS = 10,
    parameter int MIN_GAP     = 26
) (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic byte_valid,
    input logic byte_ready,
    input logic wr_pulse
);
    logic [15:0] hi_len_q;
    logic [15:0] since_rise_q;
    logic [15:0] wr_off_q;
    logic        pulse_d_q;

    // Length of the current high phase of wr_pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_len_q <= '0;
        else if (wr_pulse) hi_len_q <= hi_len_q + 16'd1;
        else               hi_len_q <= '0;
    end

    // Ticks since the last rising edge of wr_pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rise_q <= 16'hFFFF;
            pulse_d_q    <= 1'b0;
        end else begin
            pulse_d_q <= wr_pulse;
            if (wr_pulse && !pulse_d_q)       since_rise_q <= 16'd1;
            else if (since_rise_q != 16'hFFFF) since_rise_q <= since_rise_q + 16'd1;
        end
    end

    // Ticks the write gate has been low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_en)           wr_off_q <= '0;
        else if (wr_off_q != 16'hFFFF) wr_off_q <= wr_off_q + 16'd1;
    end

    assert_reset_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!wr_pulse && byte_ready));

    assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_pulse) |-> (hi_len_q == 16'(PULSE_TICKS)));

    assert_pulse_not_long_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> (hi_len_q < 16'(PULSE_TICKS)));

    assert_min_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !pulse_d_q) |-> (since_rise_q >= 16'(MIN_GAP)));

    assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready) |=> !byte_ready);

    assert_quiet_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_off_q > 16'(CELL_TICKS + PULSE_TICKS + 2)) |-> !wr_pulse);

endmodule

bind mfm_write_enc mfm_write_enc_chk #(
    .CELL_TICKS  (CELL_TICKS),
    .PULSE_TICKS (PULSE_TICKS),
    .MIN_GAP     (CELL_TICKS / 2 - (LATE_DLY - EARLY_DLY))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .wr_pulse   (wr_pulse)
);

// File: tb/mfm_write_enc_test.sv
// Directed bench for the MFM write encoder: a reference model of the
// requirements predicts every transition; observed pulse edges are compared.
module mfm_write_enc_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       byte_valid = 1'b0;
    logic       byte_ready;
    logic       mark_in = 1'b0;
    logic [6:0] track = 7'd0;
    logic       wr_pulse;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    int rises [0:255];
    int widths[0:255];
    int nr = 0;
    int nw = 0;
    logic prev_p = 1'b0;

    logic [7:0] sb[0:3];
    logic       sm[0:3];
    int         nb = 0;
    int         exp_t[0:255];
    int         ne = 0;

    always #10 clk = ~clk;

    mfm_write_enc uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .byte_in(byte_in),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .mark_in(mark_in),
        .track(track), .wr_pulse(wr_pulse)
    );

    // Records rising edges and widths of wr_pulse, away from the active edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        prev_p <= wr_pulse;
        if (wr_pulse && !prev_p && nr < 256) begin
            rises[nr] = cyc;
            nr = nr + 1;
        end
        if (!wr_pulse && prev_p && nw < 256) begin
            widths[nw] = cyc - rises[nw];
            nw = nw + 1;
        end
        if (cyc > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic m);
        @(negedge clk);
        while (!byte_ready) @(negedge clk);
        byte_in = b;
        mark_in = m;
        byte_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
        mark_in = 1'b0;
    endtask

    function automatic int shift_dly(input bit pc, input bit p, input bit n);
        if (pc && p && !n)  return 5;
        if (pc && !p && n)  return 19;
        return 12;
    endfunction

    // Reference model built from R1, R2, R3, R5 and R7.
    task automatic model(input bit pc);
        bit d[0:31];
        bit mk[0:31];
        int nbits;
        bit pd, pck, ck, eck, dn, cn;
        int cnt;
        nbits = nb * 8;
        for (int i = 0; i < nbits; i++) begin
            d[i]  = sb[i/8][7 - (i % 8)];
            mk[i] = sm[i/8];
        end
        pd = 0; pck = 0; cnt = 0; ne = 0;
        for (int i = 0; i < nbits; i++) begin
            if (i % 8 == 0) cnt = 0;
            dn  = (i + 1 < nbits) ? d[i+1] : 1'b0;
            ck  = !pd && !d[i];
            eck = ck && !(mk[i] && cnt == 1);
            if (ck) cnt++;
            cn  = !d[i] && !dn;
            if (eck) begin exp_t[ne] = i*80 + shift_dly(pc, pck, cn); ne++; end
            if (d[i]) begin exp_t[ne] = i*80 + 40 + shift_dly(pc, pd, dn); ne++; end
            pck = eck;
            pd  = d[i];
        end
    endtask

    // Writes the queued bytes on one track and compares every pulse.
    task automatic stream_test(input string req, input logic [6:0] trk);
        track = trk;
        nr = 0; nw = 0;
        wr_en = 1'b1;
        for (int k = 0; k < nb; k++) send_byte(sb[k], sm[k]);
        repeat (1500) @(negedge clk);
        wr_en = 1'b0;
        model(trk >= 7'd43);
        check(nr == ne, {req, " pulse count"}, nr, ne);
        if (nr == ne && nr > 0) begin
            for (int k = 1; k < nr; k++)
                check(rises[k] - rises[0] == exp_t[k] - exp_t[0],
                      {req, " transition offset"}, rises[k] - rises[0], exp_t[k] - exp_t[0]);
        end
        for (int k = 0; k < nw; k++)
            check(widths[k] == 10, "R6 pulse width", widths[k], 10);
    endtask

    task automatic test_reset();
        check(wr_pulse == 1'b0, "R11 wr_pulse after reset", int'(wr_pulse), 0);
        check(byte_ready == 1'b1, "R11 byte_ready after reset", int'(byte_ready), 1);
    endtask

    task automatic test_plain_outer();
        sb[0] = 8'h00; sm[0] = 0;
        sb[1] = 8'hFF; sm[1] = 0;
        sb[2] = 8'h5A; sm[2] = 0;
        nb = 3;
        stream_test("R1/R2/R3/R8", 7'd10);
    endtask

    task automatic test_track42();
        sb[0] = 8'h66; sm[0] = 0; nb = 1;
        stream_test("R4", 7'd42);
        if (nr >= 3) check(rises[2] - rises[1] == 80, "R4 no shift on track 42", rises[2] - rises[1], 80);
    endtask

    task automatic test_track43();
        sb[0] = 8'h66; sm[0] = 0;
        sb[1] = 8'h0F; sm[1] = 0;
        nb = 2;
        stream_test("R5", 7'd43);
        if (nr >= 3) check(rises[2] - rises[1] == 66, "R5 late then early in 0110", rises[2] - rises[1], 66);
    endtask

    task automatic test_marks();
        sb[0] = 8'hA1; sm[0] = 1; nb = 1;
        stream_test("R7 A1", 7'd10);
        check(nr == 5, "R7 A1 marked pulse count", nr, 5);
        sb[0] = 8'hC2; sm[0] = 1; nb = 1;
        stream_test("R7 C2", 7'd10);
        check(nr == 5, "R7 C2 marked pulse count", nr, 5);
        sb[0] = 8'hA1; sm[0] = 0; nb = 1;
        stream_test("R7 unmarked", 7'd10);
        check(nr == 6, "R7 A1 unmarked pulse count", nr, 6);
    endtask

    task automatic test_handshake();
        track = 7'd10;
        wr_en = 1'b1;
        send_byte(8'h00, 1'b0);
        repeat (240) @(negedge clk);
        check(byte_ready == 1'b0, "R9 ready low mid byte", int'(byte_ready), 0);
        repeat (250) @(negedge clk);
        check(byte_ready == 1'b1, "R9 ready high in last cells", int'(byte_ready), 1);
        repeat (800) @(negedge clk);
        wr_en = 1'b0;
        check(byte_ready == 1'b1, "R9 ready high when idle", int'(byte_ready), 1);
    endtask

    task automatic test_stop();
        track = 7'd10;
        nr = 0; nw = 0;
        wr_en = 1'b1;
        send_byte(8'h00, 1'b0);
        repeat (199) @(negedge clk);
        wr_en = 1'b0;
        repeat (800) @(negedge clk);
        check(nr == 3, "R10 pulses after write gate drop", nr, 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_plain_outer();
        test_track42();
        test_track43();
        test_marks();
        test_handshake();
        test_stop();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule